// File: doc/BRIEF.md
# Hardware Buffer Stack Manager

This block keeps a set of last-in, first-out stacks of free buffer addresses for a packet engine. Software and hardware clients reach it through memory-mapped requests. A store hands a free buffer back to a stack. A load takes the most recently returned buffer off a stack and receives a 64-bit descriptor. Each stack has a size code set by configuration, and every descriptor carries the buffer address, the stack number, that size code, a hardware-buffer marker and a two-bit validity code.

All stacks share one RAM. The RAM is split into equal partitions of `DEPTH` entries, one partition per stack, with `NSTK` stacks in total. A load never waits. If the stack is empty, the block answers at once with a descriptor whose validity code reports failure. A store to a full stack is discarded, and a sticky per-stack overflow flag records it.

The request side is a valid/ready stream. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle, so back-pressure on `rsp_ready` stalls new requests.

Each accepted load that targets this block returns exactly one response. That response appears one cycle after acceptance. It holds, unchanged, until a cycle in which `rsp_ready` is high. Stores produce no response.

Top module: `buf_stack_mgr`

## Requirements
- R1: A request targets the block only when address bits [28:26] equal 6. Address bits [7:3] give the stack number. Any other request is accepted but changes no state and produces no response.
- R2: An accepted store pushes data bits [41:7] (35-bit buffer address) onto the selected stack. All other data bits are ignored.
- R3: An accepted load pops the selected stack in last-in, first-out order.
- R4: A successful pop returns a descriptor with the following fields. Bits [63:62] are 0. Bit 58 is 1. Bits [52:48] hold the stack number. Bits [41:7] hold the buffer address. Bits [61:59] hold the size code. Every other bit is 0.
- R5: A pop from an empty stack leaves the stack unchanged and returns a descriptor with the following fields. Bits [63:62] are 3. Bits [41:7] are 0. The size code, bit 58 and the stack number are filled as in R4.
- R6: The size code of stack s is `cfg_size[3s+2:3s]`. Codes 0..7 mean 128, 256, 512, 1024, 1664, 4096, 10368 and 16384 bytes.
- R7: A stack holds at most `DEPTH` entries. A push to a full stack is dropped and sets `ovf_flags[s]`. That flag stays set until reset, and the stack contents are unchanged.
- R8: Stacks are independent. Pushes and pops on one stack never change the contents of another, including stacks in adjacent RAM partitions.
- R9: The response to an accepted load appears one cycle later with `rsp_valid` high. While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values. `req_ready` equals `!rsp_valid || rsp_ready`.
- R10: After reset every stack is empty, every overflow flag is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = store (push), 0 = load (pop) |
| req_addr | input | 29 | Request address (region [28:26], stack [7:3]) |
| req_wdata | input | 64 | Store data; buffer address in [41:7] |
| rsp_valid | output | 1 | Load descriptor present |
| rsp_ready | input | 1 | Consumer takes the descriptor |
| rsp_data | output | 64 | Load descriptor |
| cfg_size | input | 3*NSTK | Per-stack size codes |
| ovf_flags | output | NSTK | Sticky per-stack overflow flags |

## Verification
The bench builds the block with the default 32 stacks and `DEPTH` set to 4. With that setting, a stack fills after four pushes, so the overflow and drop path is reached in a few cycles. Stacks 7 and 8 sit in adjacent partitions of the shared RAM, which lets the bench test the partition boundary. Stack 31 exercises the last partition and the highest stack number. The first eight stacks carry all eight size codes.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int ADDR_W    = 29;
  localparam int IDX_W     = 5;
  localparam int VA_W      = 35;
  localparam int VA_LSB    = 7;
  localparam logic [2:0] REGION_ID = 3'd6;

  // Descriptor layout: code[63:62] size[61:59] hwb[58] inst[57:56] idx[52:48] va[41:7]
  function automatic logic [63:0] make_desc(input logic empty,
                                            input logic [2:0] size,
                                            input logic [IDX_W-1:0] idx,
                                            input logic [VA_W-1:0] va);
    logic [63:0] d;
    d          = '0;
    d[63:62]   = empty ? 2'b11 : 2'b00;
    d[61:59]   = size;
    d[58]      = 1'b1;
    d[52:48]   = idx;
    d[41:7]    = empty ? '0 : va;
    return d;
  endfunction
endpackage

// File: rtl/bsm_decode.sv
module bsm_decode
  import bsm_pkg::*;
#(
  parameter int NSTK = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic unused_addr_bits;

  assign idx = addr[7:3];
  // R1: region field must name this block, stack number must exist
  assign hit = (addr[28:26] == REGION_ID) && (int'(idx) < NSTK);
  assign unused_addr_bits = ^{addr[25:8], addr[2:0]};
endmodule

// File: rtl/bsm_occupancy.sv
module bsm_occupancy #(
  parameter int NSTK  = 32,
  parameter int DEPTH = 16,
  localparam int SI_W = $clog2(NSTK),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [SI_W-1:0] sel,
  output logic [CW-1:0]   sel_cnt,
  output logic            sel_empty,
  output logic            sel_full,
  output logic [NSTK-1:0] ovf
);
  logic [CW-1:0] cnt   [NSTK];
  logic          ovf_r [NSTK];

  assign sel_cnt   = cnt[sel];
  assign sel_empty = (sel_cnt == '0);
  assign sel_full  = (sel_cnt == CW'(DEPTH));

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    logic mine;
    logic full_g;
    assign mine   = (sel == SI_W'(g));
    assign full_g = (cnt[g] == CW'(DEPTH));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g]   <= '0;
        ovf_r[g] <= 1'b0;
      end else if (mine) begin
        if (push && !full_g)          cnt[g] <= cnt[g] + 1'b1;
        else if (pop && cnt[g] != '0) cnt[g] <= cnt[g] - 1'b1;
        if (push && full_g)           ovf_r[g] <= 1'b1;
      end
    end
    assign ovf[g] = ovf_r[g];

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CW'(DEPTH));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_r[g] |=> ovf_r[g]);
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && mine && full_g) |=> (cnt[g] == CW'(DEPTH)) && ovf_r[g]);
  end
endmodule

// File: rtl/bsm_store.sv
module bsm_store #(
  parameter int NSTK  = 32,
  parameter int DEPTH = 16,
  parameter int W     = 35,
  localparam int TOT  = NSTK * DEPTH,
  localparam int AW   = $clog2(TOT)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [TOT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/buf_stack_mgr.sv
module buf_stack_mgr
  import bsm_pkg::*;
#(
  parameter int NSTK  = 32,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_data,
  input  logic [3*NSTK-1:0] cfg_size,
  output logic [NSTK-1:0]   ovf_flags
);
  localparam int SI_W = $clog2(NSTK);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AW   = $clog2(NSTK * DEPTH);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [SI_W-1:0]  sel;
  logic             acc, push, pop;
  logic [CW-1:0]    cnt;
  logic             empty, full;
  logic [AW-1:0]    base, waddr, raddr;
  logic [VA_W-1:0]  rdata;
  logic [2:0]       size;
  logic             unused_wdata_bits;

  bsm_decode #(.NSTK(NSTK)) u_dec (.addr(req_addr), .hit(hit), .idx(idx));

  assign sel       = idx[SI_W-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready && hit;
  assign push      = acc && req_write;
  assign pop       = acc && !req_write;

  bsm_occupancy #(.NSTK(NSTK), .DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .sel(sel),
    .sel_cnt(cnt), .sel_empty(empty), .sel_full(full), .ovf(ovf_flags));

  assign base  = AW'(sel) * AW'(DEPTH);
  assign waddr = base + AW'(cnt);
  assign raddr = base + AW'(cnt) - 1'b1;

  bsm_store #(.NSTK(NSTK), .DEPTH(DEPTH), .W(VA_W)) u_ram (
    .clk(clk), .we(push && !full), .waddr(waddr),
    .wdata(req_wdata[VA_LSB +: VA_W]), .raddr(raddr), .rdata(rdata));

  assign size = cfg_size[3*sel +: 3];
  assign unused_wdata_bits = ^{req_wdata[63:42], req_wdata[6:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (pop) begin
      rsp_valid <= 1'b1;
      rsp_data  <= make_desc(empty, size, idx, rdata);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  assert_load_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rsp_valid);
  assert_empty_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (rsp_data[63:62] == 2'b11) && (rsp_data[41:7] == '0));
  assert_desc_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[58] && (rsp_data[63:62] == 2'b00 || rsp_data[63:62] == 2'b11)));
endmodule

// File: tb/tb_buf_stack_mgr.sv
`timescale 1ns/1ps
module tb_buf_stack_mgr;
  localparam int NSTK  = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [28:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [63:0] rsp_data;
  logic [3*NSTK-1:0] cfg_size;
  logic [NSTK-1:0] ovf_flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  buf_stack_mgr #(.NSTK(NSTK), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cfg_size(cfg_size), .ovf_flags(ovf_flags));

  function automatic logic [2:0] sz(input int s);
    return 3'(s % 8);
  endfunction

  function automatic logic [63:0] good(input int s, input logic [34:0] va);
    return {2'b00, sz(s), 1'b1, 2'b00, 3'b000, 5'(s), 6'b0, va, 7'b0};
  endfunction

  function automatic logic [63:0] none(input int s);
    return {2'b11, sz(s), 1'b1, 2'b00, 3'b000, 5'(s), 6'b0, 35'b0, 7'b0};
  endfunction

  function automatic logic [28:0] adr(input int s, input logic [2:0] reg_id);
    return {reg_id, 18'h2A5A5, 5'(s), 3'b101};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int s, input logic [34:0] va, input logic [2:0] reg_id = 3'd6);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = adr(s, reg_id);
    req_wdata = {22'h3FFFFF, va, 7'h7F};  // junk outside [41:7] (R2)
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pop(input int s, output logic v, output logic [63:0] d,
                     input logic [2:0] reg_id = 3'd6);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = adr(s, reg_id);
    @(posedge clk); #1;
    v = rsp_valid; d = rsp_data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input int s, input logic [63:0] exp);
    logic v; logic [63:0] d;
    pop(s, v, d);
    chk({req, " valid"}, 64'(v), 64'd1);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R10 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10 ovf_flags", 64'(ovf_flags), 64'd0);
    chk("R9 req_ready idle", 64'(req_ready), 64'd1);
    pop_chk("R10 empty after reset", 0, none(0));
  endtask

  task automatic t_lifo;
    push(5, 35'h1_2345_6789);
    push(5, 35'h7_0000_0001);
    push(5, 35'h4_ABCD_EF01);
    pop_chk("R3 lifo top", 5, good(5, 35'h4_ABCD_EF01));
    pop_chk("R3 lifo mid", 5, good(5, 35'h7_0000_0001));
    pop_chk("R4 R2 lifo bottom", 5, good(5, 35'h1_2345_6789));
    pop_chk("R5 empty pop", 5, none(5));
    pop_chk("R5 still empty", 5, none(5));
  endtask

  task automatic t_sizes;
    for (int s = 0; s < 8; s++) pop_chk("R6 size code", s, none(s));
  endtask

  task automatic t_full;
    for (int i = 1; i <= DEPTH; i++) push(31, 35'(i * 11));
    chk("R7 no overflow at full", 64'(ovf_flags), 64'd0);
    push(31, 35'h5_5555_5555);
    chk("R7 overflow flag", 64'(ovf_flags), 64'(32'h8000_0000));
    for (int i = DEPTH; i >= 1; i--) pop_chk("R7 contents kept", 31, good(31, 35'(i * 11)));
    pop_chk("R7 dropped push absent", 31, none(31));
    chk("R7 flag sticky", 64'(ovf_flags), 64'(32'h8000_0000));
  endtask

  task automatic t_isolation;
    push(1, 35'h0_0000_0AAA);
    pop_chk("R8 neighbour 2 empty", 2, none(2));
    pop_chk("R8 neighbour 0 empty", 0, none(0));
    for (int i = 1; i <= DEPTH; i++) push(7, 35'(100 + i));
    push(8, 35'h3_3333_3333);
    pop_chk("R8 partition 8", 8, good(8, 35'h3_3333_3333));
    pop_chk("R8 partition 7 top", 7, good(7, 35'(100 + DEPTH)));
    pop_chk("R8 stack 1 intact", 1, good(1, 35'h0_0000_0AAA));
    chk("R8 flags unchanged", 64'(ovf_flags), 64'(32'h8000_0000));
  endtask

  task automatic t_region;
    logic v; logic [63:0] d;
    push(3, 35'h2_2222_2222, 3'd5);
    pop(3, v, d, 3'd4);
    chk("R1 no response off-region", 64'(v), 64'd0);
    pop_chk("R1 off-region push ignored", 3, none(3));
  endtask

  task automatic t_backpressure;
    logic [63:0] held;
    push(9, 35'h6_1234_5678);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = adr(9, 3'd6);
    @(posedge clk); #1;
    chk("R9 response next cycle", 64'(rsp_valid), 64'd1);
    chk("R9 response data", rsp_data, good(9, 35'h6_1234_5678));
    chk("R9 ready low while held", 64'(req_ready), 64'd0);
    held = rsp_data;
    @(negedge clk);
    req_write = 1'b1; req_wdata = {22'h0, 35'h1_1111_1111, 7'h0};
    @(posedge clk); #1;
    chk("R9 held valid", 64'(rsp_valid), 64'd1);
    chk("R9 held data", rsp_data, held);
    @(negedge clk);
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R9 drained", 64'(rsp_valid), 64'd0);
    pop_chk("R9 stalled push not taken", 9, none(9));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSTK; s++) cfg_size[3*s +: 3] = sz(s);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_lifo();
    t_sizes();
    t_full();
    t_isolation();
    t_region();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule